// File: doc/BRIEF.md
# SMBus Indexed-Block Register Target

This block is a target-only SMBus interface that holds a small bank of 8-bit control registers for a clock-output controller. A bus host reaches the bank with two transfer types and no others. The indexed block write sends the device address, a starting register index and a byte count, then that many data bytes. The indexed block read sends the address and a starting index, then a repeated START with the read address. In reply the target returns a byte count and then register contents from the starting index upward. The four writable registers drive the parallel `cfg_q` bus that the output-control logic uses. A fifth register is a fixed identification code that cannot be written.

SCL and SDA reach the block through a two-flop synchroniser and a glitch filter. The target samples SDA on filtered SCL rising edges and moves its own SDA drive only after a filtered SCL falling edge. It models the open-drain pin with `sda_out_en`: a 1 pulls the line low. While `pwr_down` is high the block holds its sequencer idle and leaves the line alone. The register contents are kept during that time.

Top module: `smb_regblk`

## Requirements
- R1: After reset, `cfg_q` equals 32'h0000_0F07 and `sda_out_en` is 0. Register i sits at `cfg_q[8*i +: 8]`, so register 0 = 0x07, register 1 = 0x0F, register 2 = 0x00 and register 3 = 0x00.
- R2: The target acknowledges (pulls SDA low in the ninth clock) only the address byte whose upper seven bits are 1101110, with bit 0 = 0 for write and 1 for read. On any other address it gives no acknowledge and keeps SDA released until the next START.
- R3: In a write, the byte after the address is the starting index and the next is the byte count N. The following N data bytes land in consecutive registers from that index, and each is acknowledged. Data bytes beyond N get no acknowledge and change nothing.
- R4: A write byte count of 0 gets no acknowledge. No later byte of that transaction is acknowledged or stored.
- R5: A data byte aimed at index 4 is acknowledged but discarded. A data byte aimed at index 5 or above gets no acknowledge, and the rest of the transaction is ignored.
- R6: In a read, the first byte returned is 5 minus the starting index (0 when the index is 5 or more). Bytes from the starting index upward follow. Index 4 returns 0x20 and any index of 5 or more returns 0xFF.
- R7: The target keeps sending while the host acknowledges each byte. After a host NACK it releases SDA and stays off the bus until the next START.
- R8: While `pwr_down` is 1 the target acknowledges nothing, keeps SDA released and changes no register.
- R9: A pulse on SCL or SDA shorter than FILT_CYC (3) clock cycles after synchronisation has no effect on the transfer.
- R10: A STOP at any point returns the target to idle without storing a partial byte. While SCL is high and SDA steady, `sda_out_en` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | High: bus ignored, sequencer held idle |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_out_en | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_q | output | 32 | Writable registers, register i at bits 8*i+7 down to 8*i |

## Verification
A corrupted bit counter or sequencer state shows within one byte time. The ninth-clock acknowledge lands in the wrong slot, or a returned byte comes back shifted. The host-side model compares each acknowledge and each read bit as it happens. A wrong index pointer or count shows in the next data byte, either as a write to the wrong field of `cfg_q` or as a wrong read value. A stuck drive shows as `sda_out_en` high on an idle bus. Both `cfg_q` and `sda_out_en` are compared against the model on every clock between transactions.

// File: rtl/smb_pkg.sv
// Shared types for the SMBus register target.
// Assumes: byte-wide registers, 8-bit register index on the bus.
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 8;

    // Sequencer states of the target.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_OFFS,
        ST_CNT,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } smb_state_e;

    // Bus events derived from filtered SCL/SDA.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic hold_hi;   // SCL high on both samples and SDA unchanged
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/smb_filter.sv
// Synchroniser plus persistence filter for one bus line.
// Output follows the synchronised input only after it has differed from the
// output for FILT_CYC consecutive cycles. Assumes SYNC_STAGES >= 2.
module smb_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;
    logic                   sync_last;

    assign sync_last = sync_q[SYNC_STAGES-1];

    // Synchroniser chain, idle-high bus level after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // Persistence counter: accept a new level only after FILT_CYC samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            dout  <= 1'b1;
        end else if (sync_last == dout) begin
            run_q <= '0;
        end else if (run_q == CNT_W'(FILT_CYC - 1)) begin
            dout  <= sync_last;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9: output only ever moves to the level the synchroniser presented.
    p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (dout == $past(sync_last)));

    // R9: persistence counter stays within its window.
    p_run_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CNT_W'(FILT_CYC));

endmodule

// File: rtl/smb_cond.sv
// Bus condition detector: SCL edges, START and STOP from filtered lines.
// Assumes inputs are already synchronised and glitch filtered.
module smb_cond
    import smb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Event decode from current and previous samples.
    always_comb begin
        ev.rise    = scl & ~scl_q;
        ev.fall    = ~scl & scl_q;
        ev.start   = scl & scl_q & sda_q & ~sda;
        ev.stop    = scl & scl_q & ~sda_q & sda;
        ev.hold_hi = scl & scl_q & (sda == sda_q);
        ev.sda     = sda;
    end

endmodule

// File: rtl/smb_regbank.sv
// Register bank: NUM_RW writable byte registers plus one fixed ID register
// at index NUM_RW. Reads above the ID index return all ones.
// Assumes the caller only asserts wr_en for writable indices.
module smb_regbank
    import smb_pkg::*;
#(
    parameter int                       NUM_RW  = 4,
    parameter logic [BYTE_W-1:0]        ID_VAL  = 8'h20,
    parameter logic [NUM_RW*BYTE_W-1:0] RST_VAL = 32'h0000_0F07
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_RW*BYTE_W-1:0]   cfg_q
);
    logic [BYTE_W-1:0] regs [NUM_RW];

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        // One writable register with its own reset value.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs[i] <= RST_VAL[i*BYTE_W +: BYTE_W];
            else if (wr_en && (wr_idx == IDX_W'(i)))     regs[i] <= wr_data;
        end
        assign cfg_q[i*BYTE_W +: BYTE_W] = regs[i];
    end

    // Read mux: writable bank, then ID, then all-ones filler.
    always_comb begin
        if (rd_idx < IDX_W'(NUM_RW))       rd_data = regs[rd_idx[$clog2(NUM_RW)-1:0]];
        else if (rd_idx == IDX_W'(NUM_RW)) rd_data = ID_VAL;
        else                               rd_data = 8'hFF;
    end

    // R3: without a write strobe the bank holds its contents.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    // R5: a write strobe never targets the ID slot or beyond.
    p_wr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_RW)));

endmodule

// File: rtl/smb_regblk.sv
// SMBus target for indexed block write / indexed block read of a small
// register bank. Samples SDA on filtered SCL rise, changes its drive after
// filtered SCL fall. Assumes SCL is slower than the filter latency and that
// the host never stretches the clock.
module smb_regblk
    import smb_pkg::*;
#(
    parameter logic [6:0]               DEV_ADDR    = 7'b1101110,
    parameter int                       NUM_RW      = 4,
    parameter logic [BYTE_W-1:0]        ID_VAL      = 8'h20,
    parameter logic [NUM_RW*BYTE_W-1:0] RST_VAL     = 32'h0000_0F07,
    parameter int                       SYNC_STAGES = 2,
    parameter int                       FILT_CYC    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_down,
    input  logic                     scl_in,
    input  logic                     sda_in,
    output logic                     sda_out_en,
    output logic [NUM_RW*BYTE_W-1:0] cfg_q
);
    localparam int NUM_REGS = NUM_RW + 1;

    logic [1:0]        raw_line;
    logic [1:0]        filt_line;
    bus_ev_t           ev;

    smb_state_e        state;
    smb_state_e        after_ack;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [3:0]        bit_idx;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] remain;
    logic              m_ack;
    logic              sda_oe;

    logic              rx_done;
    logic              rx_ack;
    smb_state_e        rx_next;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] rd_cnt;
    logic              in_rx;

    assign raw_line = {sda_in, scl_in};

    // One filter per bus line; index 0 is SCL, index 1 is SDA.
    for (genvar g = 0; g < 2; g++) begin : g_line
        smb_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYC    (FILT_CYC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_line[g]),
            .dout  (filt_line[g])
        );
    end

    smb_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (filt_line[0]),
        .sda   (filt_line[1]),
        .ev    (ev)
    );

    smb_regbank #(
        .NUM_RW  (NUM_RW),
        .ID_VAL  (ID_VAL),
        .RST_VAL (RST_VAL)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (shreg),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

    assign in_rx   = (state == ST_ADDR) || (state == ST_OFFS) ||
                     (state == ST_CNT)  || (state == ST_WDAT);
    assign rx_done = in_rx && ev.fall && (bit_idx == 4'd8);
    assign rd_cnt  = (ptr < IDX_W'(NUM_REGS)) ? (BYTE_W'(NUM_REGS) - ptr) : '0;
    assign wr_en   = !pwr_down && (state == ST_WDAT) && rx_done && rx_ack &&
                     (ptr < IDX_W'(NUM_RW));
    assign sda_out_en = sda_oe;

    // Acknowledge decision and follow-on state for a completed received byte.
    always_comb begin
        rx_ack  = 1'b0;
        rx_next = ST_IGNORE;
        unique case (state)
            ST_ADDR: begin
                rx_ack  = (shreg[7:1] == DEV_ADDR);
                rx_next = shreg[0] ? ST_TX : ST_OFFS;
            end
            ST_OFFS: begin
                rx_ack  = 1'b1;
                rx_next = ST_CNT;
            end
            ST_CNT: begin
                rx_ack  = (shreg != '0);
                rx_next = ST_WDAT;
            end
            ST_WDAT: begin
                rx_ack  = (remain != '0) && (ptr < IDX_W'(NUM_REGS));
                rx_next = ST_WDAT;
            end
            default: begin
                rx_ack  = 1'b0;
                rx_next = ST_IGNORE;
            end
        endcase
    end

    // Main sequencer: bit shifting, acknowledge drive and pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            shreg     <= '0;
            txsh      <= '0;
            bit_idx   <= '0;
            ptr       <= '0;
            remain    <= '0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (pwr_down) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ADDR;
            bit_idx <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_OFFS, ST_CNT, ST_WDAT: begin
                    if (ev.rise && (bit_idx < 4'd8)) begin
                        shreg   <= {shreg[6:0], ev.sda};
                        bit_idx <= bit_idx + 1'b1;
                    end else if (rx_done) begin
                        bit_idx <= '0;
                        if (rx_ack) begin
                            state     <= ST_ACK;
                            after_ack <= rx_next;
                            sda_oe    <= 1'b1;
                            if (state == ST_OFFS) ptr <= shreg;
                            if (state == ST_CNT)  remain <= shreg;
                            if (state == ST_WDAT) begin
                                remain <= remain - 1'b1;
                                ptr    <= (ptr == '1) ? ptr : ptr + 1'b1;
                            end
                        end else begin
                            state  <= ST_IGNORE;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        state   <= after_ack;
                        bit_idx <= '0;
                        if (after_ack == ST_TX) begin
                            txsh   <= rd_cnt;
                            sda_oe <= ~rd_cnt[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bit_idx == 4'd7) begin
                            state   <= ST_MACK;
                            bit_idx <= '0;
                            sda_oe  <= 1'b0;
                        end else begin
                            txsh    <= {txsh[6:0], 1'b0};
                            sda_oe  <= ~txsh[6];
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        m_ack <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (m_ack) begin
                            state  <= ST_TX;
                            txsh   <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= (ptr == '1) ? ptr : ptr + 1'b1;
                        end else begin
                            state  <= ST_IGNORE;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R10: drive never moves while SCL is high and SDA is steady.
    p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        ev.hold_hi |=> $stable(sda_oe));

    // R10: a STOP always lands the sequencer in idle.
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.stop && !pwr_down) |=> (state == ST_IDLE));

    // R2: idle or ignoring target never pulls SDA.
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_IGNORE)) |-> !sda_oe);

    // R8: power-down forces idle and released SDA on the next cycle.
    p_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> ((state == ST_IDLE) && !sda_oe));

    // R4: a zero byte count drops the transaction.
    p_cnt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CNT) && rx_done && (shreg == '0) && !pwr_down) |=> (state == ST_IGNORE));

endmodule

// File: tb/test_smb_regblk.sv
// Host-side bench: drives SCL/SDA as a bus host, keeps a behavioural model of
// the register bank and compares acknowledges, read bytes and outputs.
module test_smb_regblk;
    localparam int H    = 12;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        scl_m = 1'b1;
    logic        scl_gl = 1'b0;
    logic        sda_m = 1'b1;
    logic        sda_out_en;
    logic [31:0] cfg_q;
    logic        sda_bus;
    logic        scl_bus;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          quiet = 1'b0;
    logic [7:0]  m_reg [4];

    assign sda_bus = sda_m & ~sda_out_en;
    assign scl_bus = scl_m & ~scl_gl;

    always #10 clk = ~clk;

    smb_regblk i_smb_regblk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .scl_in     (scl_bus),
        .sda_in     (sda_bus),
        .sda_out_en (sda_out_en),
        .cfg_q      (cfg_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cfg();
        return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
    endfunction

    function automatic logic [7:0] exp_rd(input int idx);
        if (idx < 4)       return m_reg[idx];
        else if (idx == 4) return 8'h20;
        else               return 8'hFF;
    endfunction

    // Per-clock comparison of outputs while the bus is idle.
    always @(negedge clk) begin
        if (quiet) begin
            chk(cfg_q == exp_cfg(), "R3 register outputs", cfg_q, exp_cfg());
            chk(!sda_out_en, "R7 bus released when idle", {31'd0, sda_out_en}, 32'd0);
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit gl, output logic s);
        sda_m = b;
        wt(H);
        scl_m = 1'b1;
        if (gl) begin
            wt(4);
            scl_gl = 1'b1;
            wt(2);
            scl_gl = 1'b0;
            wt(H - 6);
        end else begin
            wt(H);
        end
        s = sda_bus;
        scl_m = 1'b0;
        wt(H);
    endtask

    task automatic byte_out(input logic [7:0] b, input bit gl, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], gl, s);
        send_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic byte_in(input bit host_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, 1'b0, s);
            d[i] = s;
        end
        send_bit(!host_ack, 1'b0, s);
    endtask

    task automatic bus_start();
        quiet = 1'b0;
        if (!scl_m) begin
            sda_m = 1'b1;
            wt(H);
            scl_m = 1'b1;
            wt(H);
        end
        sda_m = 1'b0;
        wt(H);
        scl_m = 1'b0;
        wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wt(H);
        scl_m = 1'b1;
        wt(H);
        sda_m = 1'b1;
        wt(4 * H);
        quiet = 1'b1;
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] off, input logic [7:0] cnt,
                             input int n, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input logic [7:0] d3,
                             input bit gl, input string tag);
        logic [7:0] d [4];
        bit ack;
        bit alive;
        bit ok;
        int ptr;
        int rem;
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        alive = !pwr_down && (a == 7'b1101110);
        bus_start();
        byte_out({a, 1'b0}, gl, ack);
        chk(ack == alive, $sformatf("%s address ack", tag), {31'd0, ack}, {31'd0, alive});
        byte_out(off, gl, ack);
        chk(ack == alive, $sformatf("%s offset ack", tag), {31'd0, ack}, {31'd0, alive});
        ptr = int'(off);
        byte_out(cnt, gl, ack);
        alive = alive && (cnt != 8'h00);
        chk(ack == alive, $sformatf("%s count ack", tag), {31'd0, ack}, {31'd0, alive});
        rem = int'(cnt);
        for (int i = 0; i < n; i++) begin
            ok = alive && (rem != 0) && (ptr < 5);
            if (ok && ptr < 4) m_reg[ptr] = d[i];
            byte_out(d[i], gl, ack);
            chk(ack == ok, $sformatf("%s data ack %0d", tag, i), {31'd0, ack}, {31'd0, ok});
            alive = ok;
            ptr++;
            rem--;
        end
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] off, input int n, input string tag);
        bit ack;
        logic [7:0] got;
        logic [7:0] exp;
        bus_start();
        byte_out({7'b1101110, 1'b0}, 1'b0, ack);
        chk(ack, $sformatf("%s address ack", tag), {31'd0, ack}, 32'd1);
        byte_out(off, 1'b0, ack);
        chk(ack, $sformatf("%s offset ack", tag), {31'd0, ack}, 32'd1);
        bus_start();
        byte_out({7'b1101110, 1'b1}, 1'b0, ack);
        chk(ack, $sformatf("%s read address ack", tag), {31'd0, ack}, 32'd1);
        for (int j = 0; j < n; j++) begin
            byte_in(j < n - 1, got);
            if (j == 0) exp = (off < 8'd5) ? 8'd5 - off : 8'd0;
            else        exp = exp_rd(int'(off) + j - 1);
            chk(got == exp, $sformatf("%s byte %0d", tag, j), {24'd0, got}, {24'd0, exp});
        end
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wt(WDOG);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        bit ack;
        logic s;
        m_reg[0] = 8'h07; m_reg[1] = 8'h0F; m_reg[2] = 8'h00; m_reg[3] = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(2);
        chk(cfg_q == 32'h0000_0F07, "R1 reset value", cfg_q, 32'h0000_0F07);
        chk(!sda_out_en, "R1 SDA released after reset", {31'd0, sda_out_en}, 32'd0);
        quiet = 1'b1;
        wt(20);

        write_txn(7'b1101110, 8'd0, 8'd4, 4, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 1'b0, "R3 full write");
        read_txn(8'd0, 6, "R6 read from 0");
        write_txn(7'b1101110, 8'd2, 8'd3, 3, 8'h11, 8'h22, 8'h33, 8'h00, 1'b0, "R5 write over ID");
        write_txn(7'b1101110, 8'd3, 8'd3, 3, 8'h44, 8'h55, 8'h66, 8'h00, 1'b0, "R5 write past end");
        write_txn(7'b1101110, 8'd1, 8'd0, 1, 8'h77, 8'h00, 8'h00, 8'h00, 1'b0, "R4 zero count");
        write_txn(7'b1101110, 8'd0, 8'd1, 2, 8'h5A, 8'h6B, 8'h00, 8'h00, 1'b0, "R3 beyond count");
        write_txn(7'b1101111, 8'd0, 8'd1, 1, 8'h99, 8'h00, 8'h00, 8'h00, 1'b0, "R2 wrong address");
        write_txn(7'b0101110, 8'd1, 8'd1, 1, 8'h98, 8'h00, 8'h00, 8'h00, 1'b0, "R2 wrong upper bit");
        read_txn(8'd3, 4, "R6 read across ID");
        read_txn(8'd7, 2, "R6 read out of range");
        read_txn(8'd1, 2, "R7 early host NACK");

        pwr_down = 1'b1;
        wt(4);
        write_txn(7'b1101110, 8'd0, 8'd2, 2, 8'hEE, 8'hEF, 8'h00, 8'h00, 1'b0, "R8 power down");
        pwr_down = 1'b0;
        wt(10);
        read_txn(8'd0, 3, "R8 after power down");

        write_txn(7'b1101110, 8'd1, 8'd2, 2, 8'h3C, 8'hC3, 8'h00, 8'h00, 1'b1, "R9 SCL glitch");
        read_txn(8'd1, 3, "R9 readback");

        // R10: STOP in the middle of a data byte stores nothing.
        bus_start();
        byte_out({7'b1101110, 1'b0}, 1'b0, ack);
        chk(ack, "R10 abort address ack", {31'd0, ack}, 32'd1);
        byte_out(8'd0, 1'b0, ack);
        byte_out(8'd2, 1'b0, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, s);
        bus_stop();
        write_txn(7'b1101110, 8'd2, 8'd1, 1, 8'h81, 8'h00, 8'h00, 8'h00, 1'b0, "R10 after abort");
        read_txn(8'd0, 5, "R10 readback");

        wt(20);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule